// File: doc/BRIEF.md
# Parallel Quadratic Permutation Address Generator

This block turns a window of eight consecutive trellis indices into eight permuted memory addresses in one beat, so that an iterative channel decoder can write eight extrinsic values per cycle in permuted order. The permutation is the quadratic polynomial `pi(x) = (c1*x + c2*x*x) mod N`. Read addresses stay sequential, and only the write side goes through this block.

Each of the eight lanes computes its address on its own, with no running recurrence from the previous index. The polynomial is evaluated in factored form: first `c2*x mod N`, then that is added to `c1` modulo N, and finally the sum is multiplied by `x` and reduced modulo N. No intermediate value is ever wider than twice the index width. A mode input selects either the forward coefficient pair or a second pair that the host supplies to describe the inverse mapping. The block length, the coefficients and the mode travel down the pipeline with their beat, so every cycle may use different settings.

A beat whose window runs past the end of the block is flagged, and its addresses are forced to zero.

Top module: `qpp_addr_gen`

## Requirements
- R1: With `in_mode`=0, lane j outputs `(fwd_c1*x + fwd_c2*x*x) mod blk_len`, where `x = in_base + j`.
- R2: Lane j occupies bits `[13*j+12 : 13*j]` of `out_addr`, with lane 0 in the least significant bits. The eight lanes cover indices `in_base` to `in_base+7`.
- R3: A beat sampled at clock edge k appears on the outputs after edge k+4. `out_valid` equals `in_valid` from four cycles earlier.
- R4: With `in_mode`=1, the lanes use `inv_c1` and `inv_c2` in place of `fwd_c1` and `fwd_c2`, with the same formula.
- R5: A valid beat with `in_base + 7 >= blk_len` leaves the pipeline with `out_err`=1, and all eight of its addresses equal zero.
- R6: A cycle with `in_valid`=0 produces `out_valid`=0 and `out_err`=0 four cycles later.
- R7: Synchronous active-high `rst` clears `out_valid`, `out_err` and every address to zero.
- R8: Block lengths up to 6144 produce exact results, including windows that end at index `blk_len-1`.
- R9: Every output address, and every reduced intermediate value, is below `blk_len`.
- R10: Beats with different block lengths, coefficients and modes can follow each other on consecutive cycles, and each beat gives the results for its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on the inputs |
| in_mode | input | 1 | 0 selects forward coefficients, 1 selects inverse coefficients |
| in_base | input | 13 | First index of the eight-index window |
| fwd_c1 | input | 13 | Linear coefficient of the forward polynomial |
| fwd_c2 | input | 13 | Quadratic coefficient of the forward polynomial |
| inv_c1 | input | 13 | Linear coefficient of the inverse polynomial |
| inv_c2 | input | 13 | Quadratic coefficient of the inverse polynomial |
| blk_len | input | 13 | Block length N |
| out_valid | output | 1 | Result beat present |
| out_err | output | 1 | Window of this beat exceeded the block |
| out_addr | output | 104 | Eight permuted addresses, 13 bits each |

## Verification
The bound checks on intermediate values assume that the host keeps the selected linear coefficient below `blk_len`, and they apply only when `blk_len` is nonzero. The single conditional subtract after the addition is exact only under that condition. Every stimulus vector uses coefficients below its block length. Idle cycles drive a block length of zero, which lies outside what the checks cover. The latency check relies on a warm-up counter, so it never compares against cycles before reset.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

    localparam int unsigned IDX_W   = 13;
    localparam int unsigned N_LANES = 8;
    localparam int unsigned PIPE_LAT = 4;

    // Control that rides alongside the lane datapath.
    typedef struct packed {
        logic valid;
        logic err;
    } beat_t;

    // Coefficients and length chosen for one beat.
    typedef struct packed {
        logic [IDX_W-1:0] c1;
        logic [IDX_W-1:0] c2;
        logic [IDX_W-1:0] len;
    } coef_t;

endpackage

// File: rtl/qpp_param_sel.sv
module qpp_param_sel
    import qpp_pkg::*;
#(
    parameter int unsigned AW    = IDX_W,
    parameter int unsigned LANES = N_LANES
) (
    input  logic          valid_i,
    input  logic          mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] fwd_c1_i,
    input  logic [AW-1:0] fwd_c2_i,
    input  logic [AW-1:0] inv_c1_i,
    input  logic [AW-1:0] inv_c2_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] c1_o,
    output logic [AW-1:0] c2_o,
    output beat_t         beat_o
);
    localparam logic [AW:0] LAST_OFS = (AW+1)'(LANES - 1);

    logic [AW:0] last_idx;

    always_comb begin
        c1_o        = mode_i ? inv_c1_i : fwd_c1_i;
        c2_o        = mode_i ? inv_c2_i : fwd_c2_i;
        last_idx    = {1'b0, base_i} + LAST_OFS;
        beat_o.valid = valid_i;
        beat_o.err   = valid_i && (last_idx >= {1'b0, len_i});
    end

endmodule

// File: rtl/qpp_beat_pipe.sv
module qpp_beat_pipe
    import qpp_pkg::*;
#(
    parameter int unsigned DEPTH = PIPE_LAT
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_i,
    output beat_t beat_o
);
    beat_t stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= beat_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign beat_o = stage_q[DEPTH-1];

    // R5: an error beat always carries a valid flag through the pipe
    a_r5_err_has_valid: assert property (@(posedge clk) disable iff (rst)
        beat_o.err |-> beat_o.valid);

endmodule

// File: rtl/qpp_lane.sv
module qpp_lane #(
    parameter int unsigned AW = qpp_pkg::IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] x_i,
    input  logic [AW-1:0] c1_i,
    input  logic [AW-1:0] c2_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] addr_o
);
    localparam int unsigned PW = 2 * AW;

    // Shift-and-subtract reduction of a double-width value by m.
    function automatic logic [AW-1:0] reduce(input logic [PW-1:0] v,
                                             input logic [AW-1:0] m);
        logic [AW:0] rem;
        rem = '0;
        for (int i = PW - 1; i >= 0; i--) begin
            rem = {rem[AW-1:0], v[i]};
            if (rem >= {1'b0, m}) rem = rem - {1'b0, m};
        end
        return rem[AW-1:0];
    endfunction

    // Modular add of two operands already below m.
    function automatic logic [AW-1:0] add_mod(input logic [AW-1:0] a,
                                              input logic [AW-1:0] b,
                                              input logic [AW-1:0] m);
        logic [AW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[AW-1:0];
    endfunction

    // stage 1: c2*x
    logic [AW-1:0] x1_q, c1_1_q, len1_q;
    logic [PW-1:0] prod1_q;
    // stage 2: (c2*x) mod N
    logic [AW-1:0] x2_q, c1_2_q, len2_q, red2_q;
    // stage 3: ((c1 + red) mod N) * x
    logic [AW-1:0] len3_q;
    logic [PW-1:0] prod3_q;
    // stage 4: final reduction
    logic [AW-1:0] len4_q, addr4_q;

    logic [AW-1:0] sum2;
    assign sum2 = add_mod(c1_2_q, red2_q, len2_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            x1_q <= '0; c1_1_q <= '0; len1_q <= '0; prod1_q <= '0;
            x2_q <= '0; c1_2_q <= '0; len2_q <= '0; red2_q <= '0;
            len3_q <= '0; prod3_q <= '0;
            len4_q <= '0; addr4_q <= '0;
        end else begin
            x1_q    <= x_i;
            c1_1_q  <= c1_i;
            len1_q  <= len_i;
            prod1_q <= PW'(c2_i) * PW'(x_i);

            x2_q    <= x1_q;
            c1_2_q  <= c1_1_q;
            len2_q  <= len1_q;
            red2_q  <= reduce(prod1_q, len1_q);

            len3_q  <= len2_q;
            prod3_q <= PW'(sum2) * PW'(x2_q);

            len4_q  <= len3_q;
            addr4_q <= reduce(prod3_q, len3_q);
        end
    end

    assign addr_o = addr4_q;

    // R9: first reduction lands below the block length
    a_r9_mid_below_n: assert property (@(posedge clk) disable iff (rst)
        (len2_q != '0) |-> (red2_q < len2_q));

    // R9: modular sum feeding the second multiply stays below N when c1 < N
    a_r9_sum_below_n: assert property (@(posedge clk) disable iff (rst)
        ((len2_q != '0) && (c1_2_q < len2_q)) |-> (sum2 < len2_q));

    // R9: final address lands below the block length of its own beat
    a_r9_addr_below_n: assert property (@(posedge clk) disable iff (rst)
        (len4_q != '0) |-> (addr4_q < len4_q));

endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
    import qpp_pkg::*;
#(
    parameter int unsigned AW    = IDX_W,
    parameter int unsigned LANES = N_LANES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_mode,
    input  logic [AW-1:0]       in_base,
    input  logic [AW-1:0]       fwd_c1,
    input  logic [AW-1:0]       fwd_c2,
    input  logic [AW-1:0]       inv_c1,
    input  logic [AW-1:0]       inv_c2,
    input  logic [AW-1:0]       blk_len,
    output logic                out_valid,
    output logic                out_err,
    output logic [LANES*AW-1:0] out_addr
);
    localparam int unsigned LAT = PIPE_LAT;
    localparam int unsigned WW  = $clog2(LAT + 1);

    logic [AW-1:0] sel_c1, sel_c2;
    beat_t         beat_in, beat_out;

    qpp_param_sel #(.AW(AW), .LANES(LANES)) u_sel (
        .valid_i  (in_valid),
        .mode_i   (in_mode),
        .base_i   (in_base),
        .fwd_c1_i (fwd_c1),
        .fwd_c2_i (fwd_c2),
        .inv_c1_i (inv_c1),
        .inv_c2_i (inv_c2),
        .len_i    (blk_len),
        .c1_o     (sel_c1),
        .c2_o     (sel_c2),
        .beat_o   (beat_in)
    );

    qpp_beat_pipe #(.DEPTH(LAT)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .beat_i (beat_in),
        .beat_o (beat_out)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [AW-1:0] lane_x, lane_addr;
            assign lane_x = in_base + AW'(g);

            qpp_lane #(.AW(AW)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .x_i    (lane_x),
                .c1_i   (sel_c1),
                .c2_i   (sel_c2),
                .len_i  (blk_len),
                .addr_o (lane_addr)
            );

            assign out_addr[g*AW +: AW] = beat_out.err ? '0 : lane_addr;
        end
    endgenerate

    assign out_valid = beat_out.valid;
    assign out_err   = beat_out.err;

    // Cycles since reset, saturating at the pipeline depth.
    logic [WW-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                     warm_q <= '0;
        else if (warm_q != WW'(LAT)) warm_q <= warm_q + 1'b1;
    end

    // R3: output valid follows input valid by exactly the pipeline depth
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R7: outputs stay cleared until a beat has had time to travel through
    a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (warm_q != WW'(LAT)) |-> (!out_valid && !out_err));

endmodule

// File: tb/tb_qpp_addr_gen.sv
module tb_qpp_addr_gen;

    localparam int AW = 13;
    localparam int LN = 8;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_mode = 1'b0;
    logic [AW-1:0] in_base = '0, fwd_c1 = '0, fwd_c2 = '0;
    logic [AW-1:0] inv_c1 = '0, inv_c2 = '0, blk_len = '0;
    logic          out_valid, out_err;
    logic [LN*AW-1:0] out_addr;

    always #5 clk = ~clk;

    qpp_addr_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_base(in_base), .fwd_c1(fwd_c1), .fwd_c2(fwd_c2),
        .inv_c1(inv_c1), .inv_c2(inv_c2), .blk_len(blk_len),
        .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr)
    );

    // Vector table: valid, mode, base, fwd c1/c2, inv c1/c2, length.
    localparam int V_VAL [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam int V_MOD [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0, 1};
    localparam int V_BAS [NV] = '{0, 32, 8, 6136, 0, 512, 33, 0, 6144, 104};
    localparam int V_F1  [NV] = '{3, 3, 3, 263, 263, 31, 3, 0, 263, 17};
    localparam int V_F2  [NV] = '{10, 10, 10, 480, 480, 64, 10, 0, 480, 30};
    localparam int V_G1  [NV] = '{0, 0, 27, 0, 31, 0, 0, 0, 0, 95};
    localparam int V_G2  [NV] = '{0, 0, 30, 0, 64, 0, 0, 0, 0, 118};
    localparam int V_LEN [NV] = '{40, 40, 40, 6144, 6144, 1024, 40, 0, 6144, 112};

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic int qpp(int a, int b, int x, int n);
        longint t;
        t = (longint'(a) * x + longint'(b) * x * x) % n;
        return int'(t);
    endfunction

    task automatic check(string tag, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic drive(int i);
        if (i < NV && V_VAL[i] != 0) begin
            in_valid = 1'b1;
            in_mode  = V_MOD[i][0];
            in_base  = AW'(V_BAS[i]);
            fwd_c1   = AW'(V_F1[i]);  fwd_c2 = AW'(V_F2[i]);
            inv_c1   = AW'(V_G1[i]);  inv_c2 = AW'(V_G2[i]);
            blk_len  = AW'(V_LEN[i]);
        end else begin
            in_valid = 1'b0; in_mode = 1'b0; in_base = '0;
            fwd_c1 = '0; fwd_c2 = '0; inv_c1 = '0; inv_c2 = '0; blk_len = '0;
        end
    endtask

    task automatic check_vec(int i);
        bit is_err;
        int a, b, x, e;
        if (V_VAL[i] == 0) begin
            check("R6", "idle out_valid", out_valid, 0);
            check("R6", "idle out_err", out_err, 0);
            return;
        end
        is_err = (V_BAS[i] + 7 >= V_LEN[i]);
        check("R3", "out_valid", out_valid, 1);
        check("R5", "out_err", out_err, is_err);
        a = V_MOD[i] ? V_G1[i] : V_F1[i];
        b = V_MOD[i] ? V_G2[i] : V_F2[i];
        for (int j = 0; j < LN; j++) begin
            x = V_BAS[i] + j;
            e = is_err ? 0 : qpp(a, b, x, V_LEN[i]);
            if (is_err)
                check("R5", $sformatf("zeroed lane %0d", j), out_addr[j*AW +: AW], 0);
            else if (V_MOD[i] != 0)
                check("R4", $sformatf("R2 lane %0d", j), out_addr[j*AW +: AW], e);
            else if (V_LEN[i] == 6144)
                check("R8", $sformatf("R2 lane %0d", j), out_addr[j*AW +: AW], e);
            else
                check("R1", $sformatf("R2 lane %0d", j), out_addr[j*AW +: AW], e);
            if (!is_err)
                check("R9", $sformatf("below N lane %0d", j),
                      (out_addr[j*AW +: AW] < V_LEN[i]), 1);
        end
    endtask

    initial begin
        // R7: reset state
        @(negedge clk);
        @(negedge clk);
        check("R7", "reset out_valid", out_valid, 0);
        check("R7", "reset out_err", out_err, 0);
        check("R7", "reset out_addr", (out_addr == '0), 1);
        rst = 1'b0;

        // R10: vectors issued back to back, one per cycle, settings change every beat
        for (int c = 0; c < NV + 4; c++) begin
            if (c >= 4) check_vec(c - 4);
            drive(c);
            @(negedge clk);
        end

        // R7: reset flushes a beat in flight
        drive(0);
        @(negedge clk);
        drive(NV);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R7", "flushed out_valid", out_valid, 0);
            check("R7", "flushed out_addr", (out_addr == '0), 1);
            @(negedge clk);
        end

        // R3: a lone beat appears exactly four cycles later, not earlier
        drive(1);
        @(negedge clk);
        drive(NV);
        for (int k = 1; k < 4; k++) begin
            check("R3", $sformatf("early valid at %0d", k), out_valid, 0);
            @(negedge clk);
        end
        check_vec(1);
        @(negedge clk);
        check("R6", "after lone beat", out_valid, 0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule